// File: doc/BRIEF.md
# Virtual display scan address generator

This block produces the display-buffer word address that a panel refresh engine reads while a viewport sweeps across a virtual image wider and taller than the panel. Software programs a 10-bit line stride and a start word address through a byte-wide register write port. The stride is the word distance between the first words of consecutive buffer lines. It covers pixels that are never shown, so the visible viewport can be narrower than the stored line.

The timing logic drives three strobes: frame start, line start and pixel advance. Frame start moves the scan to the start address. Each line start moves the line base on by one stride. Pixel strobes step through the packed pixels of each 16-bit word. The colour depth sets how many pixels one word holds, and so sets how often the word address moves. The outputs are the current word address and the index of the current pixel inside that word.

Top module: `vscan_addr_gen`

## Requirements
- R1: After reset, `addr_o` is 0 and `pix_idx_o` is 0.
- R2: A frame-start strobe loads the programmed start word address into both the line base and `addr_o`, and clears `pix_idx_o`. Both outputs show the new values in the cycle after the strobe.
- R3: A line-start strobe without a frame-start strobe sets the line base and `addr_o` to the previous line base plus the active stride, and clears `pix_idx_o`.
- R4: Depth codes 0, 1, 2, 3 and 4 give 16, 8, 4, 2 and 1 pixels per word. Codes 5 to 7 act as code 4. `addr_o` rises by 1 on the pixel strobe that completes the last pixel of the current word.
- R5: Each pixel strobe raises `pix_idx_o` by 1. At a word boundary `pix_idx_o` goes back to 0.
- R6: The write port places registers at these offsets:
  - offset 0: stride bits 7..0;
  - offset 1: stride bits 9..8 in data bits 1..0, with data bits 7..2 ignored;
  - offsets 2, 3 and 4: start address bits 7..0, 15..8 and 19..16, where offset 4 uses data bits 3..0.
- R7: A stride write takes effect only at the next frame-start strobe. Line strobes before that strobe keep using the previous stride.
- R8: `depth_i` is sampled only on a frame-start strobe. A change to `depth_i` in the middle of a frame has no effect.
- R9: When strobes arrive in the same cycle, frame start wins over line start, and line start wins over pixel advance.
- R10: All address arithmetic wraps modulo 2^20 words.
- R11: With a stride of 1023 and a start address of 0, the 1025th line starts at word 1047552 and the 1026th line starts at word 1048575.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write enable |
| wr_addr_i | input | 3 | Register byte offset |
| wr_data_i | input | 8 | Register write data |
| depth_i | input | 3 | Colour depth code, sampled at frame start |
| frame_i | input | 1 | Frame-start strobe |
| line_i | input | 1 | Line-start strobe |
| pix_i | input | 1 | Pixel-advance strobe |
| addr_o | output | 20 | Current display-buffer word address |
| pix_idx_o | output | 4 | Pixel index within the current word |

## Verification
The assertions assume the following:
- every strobe lasts a single cycle;
- the first frame-start strobe comes before any line or pixel strobe that matters;
- register writes never coincide with a frame-start strobe.

The stimulus pulses each strobe for one clock and drives all inputs on the falling edge. Every test is opened with a frame start, and writes are spaced at least one idle cycle away from frame strobes. Coincident strobes are applied only in the priority test, where R9 defines the outcome.

// File: rtl/vscan_pkg.sv
package vscan_pkg;
  localparam int unsigned WORD_W   = 16;
  localparam int unsigned PIX_W    = $clog2(WORD_W);
  localparam int unsigned DEPTH_W  = 3;
  localparam int unsigned REG_AW   = 3;
  localparam int unsigned STRIDE_LO_OFS = 0;
  localparam int unsigned STRIDE_HI_OFS = 1;
  localparam int unsigned START_OFS     = 2;

  // pixels-per-word mask: code c -> (WORD_W >> c) - 1, codes past 16 bpp clamp
  function automatic logic [PIX_W-1:0] ppw_mask(input logic [DEPTH_W-1:0] code);
    logic [DEPTH_W-1:0] c;
    c = (int'(code) > int'(PIX_W)) ? DEPTH_W'(PIX_W) : code;
    return {PIX_W{1'b1}} >> c;
  endfunction
endpackage

// File: rtl/vscan_regs.sv
module vscan_regs
  import vscan_pkg::*;
#(
  parameter int unsigned ADDR_W   = 20,
  parameter int unsigned STRIDE_W = 10
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                wr_en_i,
  input  logic [REG_AW-1:0]   wr_addr_i,
  input  logic [7:0]          wr_data_i,
  input  logic                frame_i,
  input  logic [DEPTH_W-1:0]  depth_i,
  output logic [STRIDE_W-1:0] stride_o,
  output logic [ADDR_W-1:0]   start_o,
  output logic [DEPTH_W-1:0]  depth_o
);
  localparam int unsigned HI_W        = STRIDE_W - 8;
  localparam int unsigned START_BYTES = (ADDR_W + 7) / 8;

  logic [7:0]               stride_lo_q;
  logic [HI_W-1:0]          stride_hi_q;
  logic [START_BYTES*8-1:0] start_q;
  logic [STRIDE_W-1:0]      stride_act_q;
  logic [DEPTH_W-1:0]       depth_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stride_lo_q <= '0;
      stride_hi_q <= '0;
      start_q     <= '0;
    end else if (wr_en_i) begin
      if (wr_addr_i == REG_AW'(STRIDE_LO_OFS)) stride_lo_q <= wr_data_i;
      if (wr_addr_i == REG_AW'(STRIDE_HI_OFS)) stride_hi_q <= wr_data_i[HI_W-1:0];
      for (int b = 0; b < int'(START_BYTES); b++) begin
        if (wr_addr_i == REG_AW'(START_OFS + b)) start_q[b*8 +: 8] <= wr_data_i;
      end
    end
  end

  // shadow -> active only at frame start
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stride_act_q <= '0;
      depth_q      <= '0;
    end else if (frame_i) begin
      stride_act_q <= {stride_hi_q, stride_lo_q};
      depth_q      <= depth_i;
    end
  end

  assign stride_o = stride_act_q;
  assign start_o  = start_q[ADDR_W-1:0];
  assign depth_o  = depth_q;

  p_stride_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !frame_i |=> $stable(stride_o));
  p_depth_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !frame_i |=> $stable(depth_o));
endmodule

// File: rtl/vscan_pix_ctr.sv
module vscan_pix_ctr
  import vscan_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               frame_i,
  input  logic               line_i,
  input  logic               pix_i,
  input  logic [DEPTH_W-1:0] depth_i,
  output logic               word_step_o,
  output logic [PIX_W-1:0]   pix_idx_o
);
  logic [PIX_W-1:0] idx_q;
  logic [PIX_W-1:0] mask;
  logic             restart;

  assign mask        = ppw_mask(depth_i);
  assign restart     = frame_i | line_i;
  assign word_step_o = pix_i & ~restart & (idx_q == mask);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                  idx_q <= '0;
    else if (restart)             idx_q <= '0;
    else if (pix_i && idx_q == mask) idx_q <= '0;
    else if (pix_i)               idx_q <= idx_q + 1'b1;
  end

  assign pix_idx_o = idx_q;

  p_idx_range_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !frame_i |=> pix_idx_o <= ppw_mask(depth_i));
  p_idx_count_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pix_i && !restart && !word_step_o |=> pix_idx_o == $past(pix_idx_o) + 1'b1);
  p_restart_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    restart |=> pix_idx_o == '0);
endmodule

// File: rtl/vscan_line_ctr.sv
module vscan_line_ctr #(
  parameter int unsigned ADDR_W   = 20,
  parameter int unsigned STRIDE_W = 10
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                frame_i,
  input  logic                line_i,
  input  logic                word_step_i,
  input  logic [ADDR_W-1:0]   start_i,
  input  logic [STRIDE_W-1:0] stride_i,
  output logic [ADDR_W-1:0]   addr_o
);
  logic [ADDR_W-1:0] base_q;
  logic [ADDR_W-1:0] addr_q;
  logic [ADDR_W-1:0] next_base;

  assign next_base = base_q + ADDR_W'(stride_i);  // wraps mod 2^ADDR_W

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      base_q <= '0;
      addr_q <= '0;
    end else if (frame_i) begin
      base_q <= start_i;
      addr_q <= start_i;
    end else if (line_i) begin
      base_q <= next_base;
      addr_q <= next_base;
    end else if (word_step_i) begin
      addr_q <= addr_q + 1'b1;
    end
  end

  assign addr_o = addr_q;

  p_frame_load_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_i |=> addr_o == $past(start_i));
  p_line_base_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    line_i && !frame_i |=> addr_o == base_q);
  p_word_step_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    word_step_i && !frame_i && !line_i |=> addr_o == $past(addr_o) + 1'b1);
  p_addr_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !word_step_i && !frame_i && !line_i |=> $stable(addr_o));
endmodule

// File: rtl/vscan_addr_gen.sv
module vscan_addr_gen
  import vscan_pkg::*;
#(
  parameter int unsigned ADDR_W   = 20,
  parameter int unsigned STRIDE_W = 10
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               wr_en_i,
  input  logic [REG_AW-1:0]  wr_addr_i,
  input  logic [7:0]         wr_data_i,
  input  logic [DEPTH_W-1:0] depth_i,
  input  logic               frame_i,
  input  logic               line_i,
  input  logic               pix_i,
  output logic [ADDR_W-1:0]  addr_o,
  output logic [PIX_W-1:0]   pix_idx_o
);
  logic [STRIDE_W-1:0] stride;
  logic [ADDR_W-1:0]   start;
  logic [DEPTH_W-1:0]  depth;
  logic                word_step;

  vscan_regs #(.ADDR_W(ADDR_W), .STRIDE_W(STRIDE_W)) u_regs (
    .clk_i, .rst_ni, .wr_en_i, .wr_addr_i, .wr_data_i, .frame_i, .depth_i,
    .stride_o(stride), .start_o(start), .depth_o(depth)
  );

  vscan_pix_ctr u_pix (
    .clk_i, .rst_ni, .frame_i, .line_i, .pix_i,
    .depth_i(depth), .word_step_o(word_step), .pix_idx_o
  );

  vscan_line_ctr #(.ADDR_W(ADDR_W), .STRIDE_W(STRIDE_W)) u_line (
    .clk_i, .rst_ni, .frame_i, .line_i, .word_step_i(word_step),
    .start_i(start), .stride_i(stride), .addr_o
  );

  p_reset_r1: assert property (@(posedge clk_i)
    !rst_ni |=> (addr_o == '0 || !rst_ni));
endmodule

// File: tb/vscan_addr_gen_bench.sv
module vscan_addr_gen_bench;
  logic        clk_i = 0;
  logic        rst_ni = 0;
  logic        wr_en_i = 0;
  logic [2:0]  wr_addr_i = '0;
  logic [7:0]  wr_data_i = '0;
  logic [2:0]  depth_i = '0;
  logic        frame_i = 0, line_i = 0, pix_i = 0;
  logic [19:0] addr_o;
  logic [3:0]  pix_idx_o;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #4 clk_i = ~clk_i;

  vscan_addr_gen u_vscan_addr_gen (.*);

  typedef struct packed {
    logic [2:0]  depth;
    logic [9:0]  stride;
    logic [19:0] start;
    logic [11:0] lines;
    logic [11:0] pix;
    logic [19:0] exp_addr;
    logic [3:0]  exp_idx;
  } vec_t;

  localparam vec_t VEC [6] = '{
    '{3'd0, 10'd40,   20'h00100, 12'd3, 12'd37, 20'h0017A, 4'd5},
    '{3'd2, 10'd160,  20'h01000, 12'd2, 12'd10, 20'h01142, 4'd2},
    '{3'd4, 10'd320,  20'h00000, 12'd5, 12'd7,  20'h00647, 4'd0},
    '{3'd3, 10'd1023, 20'hFFC00, 12'd2, 12'd3,  20'h003FF, 4'd1},
    '{3'd1, 10'd80,   20'h12345, 12'd1, 12'd15, 20'h12396, 4'd7},
    '{3'd7, 10'd5,    20'h0000A, 12'd0, 12'd4,  20'h0000E, 4'd0}
  };

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr(logic [2:0] a, logic [7:0] d);
    @(negedge clk_i); wr_en_i = 1; wr_addr_i = a; wr_data_i = d;
    @(negedge clk_i); wr_en_i = 0;
  endtask

  task automatic set_stride(logic [9:0] s);
    wr(3'd0, s[7:0]); wr(3'd1, {6'b0, s[9:8]});
  endtask

  task automatic set_start(logic [19:0] a);
    wr(3'd2, a[7:0]); wr(3'd3, a[15:8]); wr(3'd4, {4'b0, a[19:16]});
  endtask

  task automatic pulse(bit f, bit l, bit p);
    @(negedge clk_i); frame_i = f; line_i = l; pix_i = p;
    @(negedge clk_i); frame_i = 0; line_i = 0; pix_i = 0;
  endtask

  task automatic summary();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected finish");
    summary();
  end

  initial begin
    repeat (3) @(negedge clk_i);
    chk("R1 addr", addr_o, 0);
    chk("R1 idx", pix_idx_o, 0);
    rst_ni = 1;
    @(negedge clk_i);

    // R2 R3 R4 R5 R6 R10 vector walk
    foreach (VEC[i]) begin
      set_stride(VEC[i].stride);
      set_start(VEC[i].start);
      depth_i = VEC[i].depth;
      pulse(1, 0, 0);
      for (int l = 0; l < int'(VEC[i].lines); l++) pulse(0, 1, 0);
      for (int p = 0; p < int'(VEC[i].pix); p++) pulse(0, 0, 1);
      chk($sformatf("R4 R10 vec%0d addr", i), addr_o, VEC[i].exp_addr);
      chk($sformatf("R5 vec%0d idx", i), pix_idx_o, VEC[i].exp_idx);
    end

    // R2: frame reload, idx cleared
    set_start(20'h00200); depth_i = 0;
    pulse(0, 0, 1);
    pulse(1, 0, 0);
    chk("R2 addr", addr_o, 20'h00200);
    chk("R2 idx", pix_idx_o, 0);

    // R5: word boundary at 16 ppw
    for (int p = 0; p < 15; p++) pulse(0, 0, 1);
    chk("R5 idx15", pix_idx_o, 15);
    chk("R5 addr held", addr_o, 20'h00200);
    pulse(0, 0, 1);
    chk("R5 idx wrap", pix_idx_o, 0);
    chk("R4 addr step", addr_o, 20'h00201);

    // R7: stride deferral
    set_stride(10'd40); set_start(20'h00000);
    pulse(1, 0, 0);
    set_stride(10'd100);
    pulse(0, 1, 0);
    chk("R7 old stride", addr_o, 40);
    pulse(1, 0, 0);
    pulse(0, 1, 0);
    chk("R7 new stride", addr_o, 100);

    // R6: upper bits of high stride byte ignored
    wr(3'd0, 8'h02); wr(3'd1, 8'hFD);
    pulse(1, 0, 0);
    pulse(0, 1, 0);
    chk("R6 stride hi", addr_o, 258);

    // R8: depth change mid-frame ignored
    depth_i = 0;
    pulse(1, 0, 0);
    depth_i = 4;
    pulse(0, 0, 1);
    chk("R8 addr", addr_o, 0);
    chk("R8 idx", pix_idx_o, 1);

    // R9: priority
    set_stride(10'd7); set_start(20'h00050);
    pulse(1, 0, 0);
    pulse(0, 1, 0);
    pulse(1, 1, 1);
    chk("R9 frame wins addr", addr_o, 20'h00050);
    chk("R9 frame wins idx", pix_idx_o, 0);
    pulse(0, 0, 1);
    pulse(0, 1, 1);
    chk("R9 line wins addr", addr_o, 20'h00057);
    chk("R9 line wins idx", pix_idx_o, 0);

    // R11: max stride vertical extent
    set_stride(10'd1023); set_start(20'h00000);
    pulse(1, 0, 0);
    for (int l = 0; l < 1024; l++) pulse(0, 1, 0);
    chk("R11 line 1025", addr_o, 1047552);
    pulse(0, 1, 0);
    chk("R11 line 1026", addr_o, 1048575);
    pulse(0, 1, 0);
    chk("R10 wrap", addr_o, 1022);

    summary();
  end
endmodule